// File: doc/BRIEF.md
# Status and Write-Enable Register

This block holds an 8-bit volatile status byte for a timekeeping register map. The byte reports whether the chip is running from its backup supply, whether either of two alarms has matched, whether the timekeeping state was lost through a total power failure, and the state of two write-enable latches. The two latches together gate every write to the rest of the register map. The status byte itself can always be written.

The host sets the latches with a fixed two-write sequence. First it writes 02h, which arms the first latch. Then it writes 06h, which arms the second latch. A write of 00h disarms both latches. Every other written value leaves the latches as they are, and a write never touches the alarm, supply or clock-fail bits.

Alarm flags clear on a status read, but only the flags that were already set when the read began. A match that arrives during the read keeps its flag set. The clock-fail flag comes up set after power-up or total power loss. It clears on the first time-register write that the latches allow.

Top module: `stat_wen_reg`

## Requirements
- R1: After reset the status byte is 01h, both latches are low and `map_wr_en_o` is low.
- R2: The status byte bit positions are fixed as follows. Bit 7 is the supply flag, bit 6 is alarm 1, bit 5 is alarm 0, bits 4 and 3 always read 0, bit 2 is the second latch, bit 1 is the first latch and bit 0 is the clock-fail flag.
- R3: Bit 7 equals `on_backup_i` as sampled at the previous clock edge. No write changes it.
- R4: A match pulse on `alarm_hit_i[i]` sets that alarm's flag from the next cycle onward. The flag stays set until a read clears it.
- R5: A pulse on `rd_done_i` clears only the flags that were set when `rd_start_i` pulsed for that read. The cleared value is visible one cycle after `rd_done_i`. A `rd_done_i` with no preceding `rd_start_i` clears nothing.
- R6: A flag set by a match after `rd_start_i`, or by a match in the same cycle as `rd_done_i`, is still set after the read.
- R7: Writing 02h sets bit 1 and clears bit 2. Writing 00h clears both bits. Each change is visible one cycle after the write strobe.
- R8: Writing 06h sets bit 2 only when bit 1 is already set. Writing any value other than 00h, 02h or 06h changes no bit of the status byte.
- R9: `map_wr_en_o` is high exactly when bits 2 and 1 are both set.
- R10: Bit 0 sets on reset and for each `pwr_lost_i` pulse. A `pwr_lost_i` pulse also clears both latches. A `time_commit_i` pulse clears bit 0 only while `map_wr_en_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| wr_en_i | input | 1 | One-cycle strobe for a host write to the status byte |
| wr_data_i | input | 8 | Value written to the status byte |
| rd_start_i | input | 1 | Pulse when a status read begins |
| rd_done_i | input | 1 | Pulse at the end of the last data bit of a status read |
| alarm_hit_i | input | NUM_ALARMS | Per-alarm match pulses |
| on_backup_i | input | 1 | High while running from the backup supply |
| pwr_lost_i | input | 1 | Pulse on power-up after a total power loss |
| time_commit_i | input | 1 | Pulse when a time-register write completes |
| stat_o | output | 8 | Current status byte |
| map_wr_en_o | output | 1 | Enables writes to the protected register map |

## Verification
Every stored bit reaches `stat_o` through a single register stage, so a wrong internal state shows at the ports one cycle after the input that caused it. A wrong read snapshot shows only when the read ends. It appears as a flag that clears when it should stay set, or stays set when it should clear, so each ordering of a match against the read strobes is tested directly. A latch that jumps out of sequence shows at once on `map_wr_en_o`, and also in whether the clock-fail bit survives a commit.

// File: rtl/stat_pkg.sv
package stat_pkg;
    localparam logic [7:0] CODE_CLR  = 8'h00;
    localparam logic [7:0] CODE_WEL  = 8'h02;
    localparam logic [7:0] CODE_RWEL = 8'h06;

    localparam int BIT_BAT  = 7;
    localparam int BIT_AL0  = 5;
    localparam int BIT_RWEL = 2;
    localparam int BIT_WEL  = 1;
    localparam int BIT_RTCF = 0;

    typedef struct packed {
        logic wel;
        logic rwel;
    } wen_t;

    typedef struct packed {
        logic flag;
        logic snap;
    } alm_t;

    typedef struct packed {
        logic bat;
    } top_t;
endpackage

// File: rtl/alarm_flag.sv
module alarm_flag
    import stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic rd_start_i,
    input  logic rd_done_i,
    output logic flag_o
);
    alm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_start_i) begin
            st_d.snap = st_q.flag;
        end
        if (rd_done_i) begin
            st_d.flag = st_q.flag & ~st_q.snap;
            st_d.snap = 1'b0;
        end
        if (hit_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    a_r4_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> flag_o);
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done_i && !rd_start_i && st_q.snap && !hit_i) |=> !flag_o);
    a_r6_unsnapped_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done_i && !st_q.snap && st_q.flag) |=> flag_o);
endmodule

// File: rtl/wen_latch.sv
module wen_latch
    import stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    input  logic       pwr_lost_i,
    output logic       wel_o,
    output logic       rwel_o
);
    wen_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pwr_lost_i) begin
            st_d = '0;
        end else if (wr_en_i) begin
            case (wr_data_i)
                CODE_CLR: begin
                    st_d.wel  = 1'b0;
                    st_d.rwel = 1'b0;
                end
                CODE_WEL: begin
                    st_d.wel  = 1'b1;
                    st_d.rwel = 1'b0;
                end
                CODE_RWEL: begin
                    if (st_q.wel) st_d.rwel = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wel_o  = st_q.wel;
    assign rwel_o = st_q.rwel;

    a_r9_order_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rwel_o |-> wel_o);
    a_r8_rwel_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !pwr_lost_i && wr_data_i == CODE_RWEL && !wel_o) |=> !rwel_o);
    a_r8_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !pwr_lost_i && wr_data_i != CODE_CLR && wr_data_i != CODE_WEL
         && wr_data_i != CODE_RWEL) |=> ($stable(wel_o) && $stable(rwel_o)));
    a_r7_clear_code: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i == CODE_CLR) |=> (!wel_o && !rwel_o));
endmodule

// File: rtl/fail_flag.sv
module fail_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_lost_i,
    input  logic commit_i,
    input  logic enabled_i,
    output logic rtcf_o
);
    logic rtcf_d, rtcf_q;

    always_comb begin
        rtcf_d = rtcf_q;
        if (pwr_lost_i)                  rtcf_d = 1'b1;
        else if (commit_i && enabled_i)  rtcf_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rtcf_q <= 1'b1;
        else        rtcf_q <= rtcf_d;
    end

    assign rtcf_o = rtcf_q;

    a_r10_loss_sets: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_lost_i |=> rtcf_o);
    a_r10_locked_commit_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !enabled_i && rtcf_o) |=> rtcf_o);
endmodule

// File: rtl/stat_wen_reg.sv
module stat_wen_reg
    import stat_pkg::*;
#(
    parameter int NUM_ALARMS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [7:0]            wr_data_i,
    input  logic                  rd_start_i,
    input  logic                  rd_done_i,
    input  logic [NUM_ALARMS-1:0] alarm_hit_i,
    input  logic                  on_backup_i,
    input  logic                  pwr_lost_i,
    input  logic                  time_commit_i,
    output logic [7:0]            stat_o,
    output logic                  map_wr_en_o
);
    // Alarm flags occupy bits BIT_AL0 upward; the byte layout fixes two of them.
    localparam int AL_TOP = BIT_AL0 + NUM_ALARMS - 1;

    top_t                  st_d, st_q;
    logic [NUM_ALARMS-1:0] al_flags;
    logic                  wel, rwel, rtcf;

    always_comb begin
        st_d     = st_q;
        st_d.bat = on_backup_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar gi = 0; gi < NUM_ALARMS; gi++) begin : g_alm
        alarm_flag i_alarm_flag (
            .clk        (clk),
            .rst_n      (rst_n),
            .hit_i      (alarm_hit_i[gi]),
            .rd_start_i (rd_start_i),
            .rd_done_i  (rd_done_i),
            .flag_o     (al_flags[gi])
        );
    end

    wen_latch i_wen_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .pwr_lost_i (pwr_lost_i),
        .wel_o      (wel),
        .rwel_o     (rwel)
    );

    fail_flag i_fail_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_lost_i (pwr_lost_i),
        .commit_i   (time_commit_i),
        .enabled_i  (map_wr_en_o),
        .rtcf_o     (rtcf)
    );

    always_comb begin
        stat_o                  = '0;
        stat_o[BIT_BAT]         = st_q.bat;
        stat_o[AL_TOP:BIT_AL0]  = al_flags;
        stat_o[BIT_RWEL]        = rwel;
        stat_o[BIT_WEL]         = wel;
        stat_o[BIT_RTCF]        = rtcf;
    end

    assign map_wr_en_o = wel & rwel;

    a_r3_bat_high: assert property (@(posedge clk) disable iff (!rst_n)
        on_backup_i |=> stat_o[BIT_BAT]);
    a_r3_bat_low: assert property (@(posedge clk) disable iff (!rst_n)
        !on_backup_i |=> !stat_o[BIT_BAT]);
    a_r9_enable_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(map_wr_en_o) |-> $past(wr_en_i && wr_data_i == CODE_RWEL));
endmodule

// File: tb/test_stat_wen_reg.sv
module test_stat_wen_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic       rd_start_i = 1'b0;
    logic       rd_done_i = 1'b0;
    logic [1:0] alarm_hit_i = '0;
    logic       on_backup_i = 1'b0;
    logic       pwr_lost_i = 1'b0;
    logic       time_commit_i = 1'b0;
    logic [7:0] stat_o;
    logic       map_wr_en_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    stat_wen_reg i_stat_wen_reg (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en_i),
        .wr_data_i     (wr_data_i),
        .rd_start_i    (rd_start_i),
        .rd_done_i     (rd_done_i),
        .alarm_hit_i   (alarm_hit_i),
        .on_backup_i   (on_backup_i),
        .pwr_lost_i    (pwr_lost_i),
        .time_commit_i (time_commit_i),
        .stat_o        (stat_o),
        .map_wr_en_o   (map_wr_en_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en_i = 1'b1; wr_data_i = v;
        step();
        wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic t_reset();
        chk("R1 status", stat_o, 8'h01);
        chk("R1 enable", {7'b0, map_wr_en_o}, 8'h00);
    endtask

    task automatic t_supply();
        on_backup_i = 1'b1;
        step();
        chk("R3 R2 supply bit set", stat_o, 8'h81);
        wr(8'hFF);
        chk("R3 R8 write ignored", stat_o, 8'h81);
        on_backup_i = 1'b0;
        step();
        chk("R3 supply bit cleared", stat_o, 8'h01);
    endtask

    task automatic t_alarm_set();
        alarm_hit_i = 2'b01; step(); alarm_hit_i = 2'b00;
        chk("R4 R2 alarm0 at bit5", stat_o, 8'h21);
        alarm_hit_i = 2'b10; step(); alarm_hit_i = 2'b00;
        chk("R4 R2 alarm1 at bit6", stat_o, 8'h61);
        step(); step();
        chk("R4 flags held", stat_o, 8'h61);
    endtask

    task automatic t_read_clear();
        rd_start_i = 1'b1; step(); rd_start_i = 1'b0;
        step();
        chk("R5 no clear before done", stat_o, 8'h61);
        rd_done_i = 1'b1; step(); rd_done_i = 1'b0;
        chk("R5 both cleared", stat_o, 8'h01);
        alarm_hit_i = 2'b01; step(); alarm_hit_i = 2'b00;
        rd_start_i = 1'b1; step(); rd_start_i = 1'b0;
        alarm_hit_i = 2'b10; step(); alarm_hit_i = 2'b00;
        rd_done_i = 1'b1; step(); rd_done_i = 1'b0;
        chk("R5 R6 alarm0 cleared alarm1 kept", stat_o, 8'h41);
        rd_start_i = 1'b1; step(); rd_start_i = 1'b0;
        rd_done_i = 1'b1; alarm_hit_i = 2'b10; step();
        rd_done_i = 1'b0; alarm_hit_i = 2'b00;
        chk("R6 hit with done kept", stat_o, 8'h41);
        rd_done_i = 1'b1; step(); rd_done_i = 1'b0;
        chk("R5 done without start", stat_o, 8'h41);
        rd_start_i = 1'b1; step(); rd_start_i = 1'b0;
        rd_done_i = 1'b1; step(); rd_done_i = 1'b0;
        chk("R5 final clear", stat_o, 8'h01);
    endtask

    task automatic t_enable_seq();
        wr(8'h06);
        chk("R8 rwel refused without wel", stat_o, 8'h01);
        wr(8'h02);
        chk("R7 wel set", stat_o, 8'h03);
        chk("R9 enable low with wel only", {7'b0, map_wr_en_o}, 8'h00);
        wr(8'h06);
        chk("R8 rwel set", stat_o, 8'h07);
        chk("R9 enable high", {7'b0, map_wr_en_o}, 8'h01);
        wr(8'h10);
        chk("R8 other value ignored", stat_o, 8'h07);
        wr(8'h02);
        chk("R7 02h clears rwel", stat_o, 8'h03);
        wr(8'h06);
        wr(8'h00);
        chk("R7 00h clears both", stat_o, 8'h01);
        chk("R9 enable low after clear", {7'b0, map_wr_en_o}, 8'h00);
    endtask

    task automatic t_fail_flag();
        time_commit_i = 1'b1; step(); time_commit_i = 1'b0;
        chk("R10 locked commit kept", stat_o, 8'h01);
        wr(8'h02); wr(8'h06);
        time_commit_i = 1'b1; step(); time_commit_i = 1'b0;
        chk("R10 commit clears", stat_o, 8'h06);
        pwr_lost_i = 1'b1; step(); pwr_lost_i = 1'b0;
        chk("R10 loss sets and drops latches", stat_o, 8'h01);
        chk("R10 R9 enable dropped", {7'b0, map_wr_en_o}, 8'h00);
    endtask

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_supply();
        t_alarm_set();
        t_read_clear();
        t_enable_seq();
        t_fail_flag();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule